// File: doc/BRIEF.md
# Two-Stage Pipelined Multi-Level 1-D Wavelet Engine

This block computes a multi-level one-dimensional discrete wavelet transform on a stream of signed fixed-point samples. Samples arrive two at a time (an even-indexed sample and the odd-indexed sample after it) under a valid/ready handshake. Each transform level runs one 4-tap low-pass filter and one 4-tap high-pass filter and keeps one output out of every two. The filters are written in polyphase form: one multiply-accumulate group handles the even samples and another handles the odd samples, in the same cycle, and their two partial sums are added.

The first pipeline stage handles only level 1. It accepts one sample pair per cycle. For each pair it produces one level-1 detail coefficient, which goes straight to its own output lane. It also produces one approximation sample, which is passed to the second stage. The second stage runs a single shared datapath for levels 2 through `MAX_LEVELS`. Each of those levels has its own pair collector and its own delay line. A priority scheduler chooses which level runs in each cycle. The second stage emits detail coefficients for every level it handles. It emits approximation coefficients only for the deepest level. Each beat on the second-stage lane carries a level number and a band flag.

Top module: `dwt1d_pipe`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `in_ready_o` is 1, `det1_valid_o` is 0 and `deep_valid_o` is 0. Reset clears every delay line, every collector and the scheduler.
- R2: For the pair n of any level, with x[2n] as the even sample and x[2n+1] as the odd sample, the low-pass result is L0*x[2n+1] + L1*x[2n] + L2*x[2n-1] + L3*x[2n-2]. The high-pass result uses H0..H3 in the same way. Defaults: L = (-4, 36, 36, -4), H = (-4, -36, 36, 4). Sums are exact in 24-bit signed arithmetic.
- R3: Any sample before the start of a level's stream counts as zero, so pair 0 of each level after reset sees zeros in its x[-1] and x[-2] positions.
- R4: The sample passed from level k to level k+1 is the level-k low-pass sum, arithmetically shifted right by `FRAC_SHIFT` (default 6), then saturated to the 12-bit range [-2048, 2047].
- R5: Level k+1 takes its input pairs from the level-k approximation samples in arrival order. The first sample of each pair is even and the second is odd, so each level halves the rate.
- R6: A beat on `deep_valid_o` has `deep_level_o` between 2 and `MAX_LEVELS`. `deep_band_o` = 1 marks a detail (high-pass) coefficient and 0 marks an approximation (low-pass) coefficient. Band 0 appears only with `deep_level_o` = `MAX_LEVELS`.
- R7: Within each level and band, coefficients come out in order. For N accepted pairs, where N is a multiple of 2^(MAX_LEVELS-1), level k produces N/2^(k-1) detail coefficients, and the deepest level produces as many approximation coefficients as detail coefficients.
- R8: `in_ready_o` goes low only when the level-2 collector holds a full pair that is not consumed in that cycle. A pair offered while `in_ready_o` is low is not taken. An input presented with `in_valid_i` low has no effect.
- R9: Levels that share the second stage keep separate filter state, so interleaving levels does not change any level's coefficients.
- R10: `det1_valid_o` pulses for exactly one cycle, on the cycle after each accepted pair, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Sample pair valid |
| in_ready_o | output | 1 | Block can take a pair this cycle |
| in_even_i | input | 12 | Even-indexed sample, signed |
| in_odd_i | input | 12 | Odd-indexed sample, signed |
| det1_valid_o | output | 1 | Level-1 detail coefficient valid |
| det1_coef_o | output | 24 | Level-1 detail coefficient, signed |
| deep_valid_o | output | 1 | Second-stage coefficient valid |
| deep_level_o | output | 3 | Level of the second-stage coefficient |
| deep_band_o | output | 1 | 1 = detail, 0 = approximation |
| deep_coef_o | output | 24 | Second-stage coefficient, signed |

## Verification
The hardest case to reach from the ports is the second stage fully loaded. Level operations and the deepest-level approximation beat then fill every slot, and the level-2 collector fills up and pushes back on the input. Back-to-back pairs with `in_valid_i` held high drive the shared stage to its full rate. Runs with random idle gaps mix the levels in other orders. Each level's and each band's coefficients are then checked in order against a convolve-and-decimate model that runs on the same input. Saturating DC inputs of both signs push the feedback path to its clamp limits.

// File: rtl/dwt_pkg.sv
package dwt_pkg;
  typedef enum logic {
    BAND_LO = 1'b0,
    BAND_HI = 1'b1
  } band_e;
endpackage

// File: rtl/dwt_polyphase_fir.sv
// 4-tap filter split into odd-phase and even-phase partial sums.
module dwt_polyphase_fir #(
  parameter int SAMPLE_W = 12,
  parameter int COEF_W   = 8,
  parameter int ACC_W    = 24,
  parameter int T0 = 0,
  parameter int T1 = 0,
  parameter int T2 = 0,
  parameter int T3 = 0
) (
  input  logic signed [SAMPLE_W-1:0] even_cur_i,
  input  logic signed [SAMPLE_W-1:0] odd_cur_i,
  input  logic signed [SAMPLE_W-1:0] even_prev_i,
  input  logic signed [SAMPLE_W-1:0] odd_prev_i,
  output logic signed [ACC_W-1:0]    acc_o
);
  localparam logic signed [COEF_W-1:0] C0 = COEF_W'(T0);
  localparam logic signed [COEF_W-1:0] C1 = COEF_W'(T1);
  localparam logic signed [COEF_W-1:0] C2 = COEF_W'(T2);
  localparam logic signed [COEF_W-1:0] C3 = COEF_W'(T3);

  logic signed [ACC_W-1:0] odd_part, even_part;

  always_comb begin
    odd_part  = ACC_W'(C0) * ACC_W'(odd_cur_i)  + ACC_W'(C2) * ACC_W'(odd_prev_i);
    even_part = ACC_W'(C1) * ACC_W'(even_cur_i) + ACC_W'(C3) * ACC_W'(even_prev_i);
    acc_o     = odd_part + even_part;
  end
endmodule

// File: rtl/dwt_requant.sv
// Scale a low-pass sum back to sample width with saturation.
module dwt_requant #(
  parameter int SAMPLE_W   = 12,
  parameter int ACC_W      = 24,
  parameter int FRAC_SHIFT = 6
) (
  input  logic signed [ACC_W-1:0]    acc_i,
  output logic signed [SAMPLE_W-1:0] sample_o
);
  localparam logic signed [ACC_W-1:0] HI_LIM = ACC_W'(2 ** (SAMPLE_W - 1) - 1);
  localparam logic signed [ACC_W-1:0] LO_LIM = ACC_W'(-(2 ** (SAMPLE_W - 1)));

  logic signed [ACC_W-1:0] shifted;

  always_comb begin
    shifted = acc_i >>> FRAC_SHIFT;
    if (shifted > HI_LIM)      sample_o = SAMPLE_W'(HI_LIM);
    else if (shifted < LO_LIM) sample_o = SAMPLE_W'(LO_LIM);
    else                       sample_o = SAMPLE_W'(shifted);
  end
endmodule

// File: rtl/dwt_stage1.sv
module dwt_stage1 #(
  parameter int SAMPLE_W   = 12,
  parameter int COEF_W     = 8,
  parameter int ACC_W      = 24,
  parameter int FRAC_SHIFT = 6,
  parameter int LO_T0 = -4, parameter int LO_T1 = 36,
  parameter int LO_T2 = 36, parameter int LO_T3 = -4,
  parameter int HI_T0 = -4, parameter int HI_T1 = -36,
  parameter int HI_T2 = 36, parameter int HI_T3 = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fire_i,
  input  logic signed [SAMPLE_W-1:0] even_i,
  input  logic signed [SAMPLE_W-1:0] odd_i,
  output logic                       det_valid_o,
  output logic signed [ACC_W-1:0]    det_coef_o,
  output logic signed [SAMPLE_W-1:0] appr_o
);
  logic signed [SAMPLE_W-1:0] prev_e_q, prev_o_q;
  logic signed [ACC_W-1:0]    acc [2];

  for (genvar b = 0; b < 2; b++) begin : g_band
    dwt_polyphase_fir #(
      .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
      .T0(b == 0 ? LO_T0 : HI_T0), .T1(b == 0 ? LO_T1 : HI_T1),
      .T2(b == 0 ? LO_T2 : HI_T2), .T3(b == 0 ? LO_T3 : HI_T3)
    ) u_fir (
      .even_cur_i (even_i),
      .odd_cur_i  (odd_i),
      .even_prev_i(prev_e_q),
      .odd_prev_i (prev_o_q),
      .acc_o      (acc[b])
    );
  end

  dwt_requant #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .FRAC_SHIFT(FRAC_SHIFT)) u_rq (
    .acc_i   (acc[0]),
    .sample_o(appr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_e_q    <= '0;
      prev_o_q    <= '0;
      det_valid_o <= 1'b0;
      det_coef_o  <= '0;
    end else begin
      det_valid_o <= fire_i;
      if (fire_i) begin
        prev_e_q   <= even_i;
        prev_o_q   <= odd_i;
        det_coef_o <= acc[1];
      end
    end
  end
endmodule

// File: rtl/dwt_stage2.sv
// Shared datapath for levels 2..MAX_LEVELS; slot j serves level j+2.
module dwt_stage2 import dwt_pkg::*; #(
  parameter int SAMPLE_W   = 12,
  parameter int COEF_W     = 8,
  parameter int ACC_W      = 24,
  parameter int FRAC_SHIFT = 6,
  parameter int MAX_LEVELS = 4,
  parameter int LVL_W      = 3,
  parameter int LO_T0 = -4, parameter int LO_T1 = 36,
  parameter int LO_T2 = 36, parameter int LO_T3 = -4,
  parameter int HI_T0 = -4, parameter int HI_T1 = -36,
  parameter int HI_T2 = 36, parameter int HI_T3 = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_valid_i,
  input  logic signed [SAMPLE_W-1:0] push_data_i,
  output logic                       push_ready_o,
  output logic                       l2_full_o,
  output logic                       out_valid_o,
  output logic [LVL_W-1:0]           out_level_o,
  output band_e                      out_band_o,
  output logic signed [ACC_W-1:0]    out_coef_o
);
  localparam int NLVL  = MAX_LEVELS - 1;
  localparam int SEL_W = (NLVL > 1) ? $clog2(NLVL) : 1;

  logic [1:0]                 cnt_q  [NLVL];
  logic signed [SAMPLE_W-1:0] ev_q   [NLVL];
  logic signed [SAMPLE_W-1:0] od_q   [NLVL];
  logic signed [SAMPLE_W-1:0] pe_q   [NLVL];
  logic signed [SAMPLE_W-1:0] po_q   [NLVL];
  logic                       hold_valid_q;
  logic signed [ACC_W-1:0]    hold_coef_q;

  logic                       room [NLVL];
  logic                       sel_valid;
  logic [SEL_W-1:0]           sel;
  logic signed [SAMPLE_W-1:0] op_e, op_o, op_pe, op_po, lo_sample;
  logic signed [ACC_W-1:0]    acc [2];

  // Scheduler: the deepest level with a full pair and downstream room wins.
  always_comb begin
    for (int j = 0; j < NLVL - 1; j++) room[j] = (cnt_q[j+1] != 2'd2);
    room[NLVL-1] = 1'b1;
    sel_valid = 1'b0;
    sel       = '0;
    if (!hold_valid_q) begin
      for (int j = 0; j < NLVL; j++) begin
        if (cnt_q[j] == 2'd2 && room[j]) begin
          sel_valid = 1'b1;
          sel       = SEL_W'(j);
        end
      end
    end
  end

  always_comb begin
    op_e  = ev_q[sel];
    op_o  = od_q[sel];
    op_pe = pe_q[sel];
    op_po = po_q[sel];
  end

  assign l2_full_o    = (cnt_q[0] == 2'd2);
  assign push_ready_o = !l2_full_o || (sel_valid && sel == '0);

  for (genvar b = 0; b < 2; b++) begin : g_band
    dwt_polyphase_fir #(
      .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
      .T0(b == 0 ? LO_T0 : HI_T0), .T1(b == 0 ? LO_T1 : HI_T1),
      .T2(b == 0 ? LO_T2 : HI_T2), .T3(b == 0 ? LO_T3 : HI_T3)
    ) u_fir (
      .even_cur_i (op_e),
      .odd_cur_i  (op_o),
      .even_prev_i(op_pe),
      .odd_prev_i (op_po),
      .acc_o      (acc[b])
    );
  end

  dwt_requant #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .FRAC_SHIFT(FRAC_SHIFT)) u_rq (
    .acc_i   (acc[0]),
    .sample_o(lo_sample)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < NLVL; j++) begin
        cnt_q[j] <= '0;
        ev_q[j]  <= '0;
        od_q[j]  <= '0;
        pe_q[j]  <= '0;
        po_q[j]  <= '0;
      end
      hold_valid_q <= 1'b0;
      hold_coef_q  <= '0;
      out_valid_o  <= 1'b0;
      out_level_o  <= '0;
      out_band_o   <= BAND_LO;
      out_coef_o   <= '0;
    end else begin
      out_valid_o <= 1'b0;
      if (hold_valid_q) begin
        out_valid_o  <= 1'b1;
        out_level_o  <= LVL_W'(MAX_LEVELS);
        out_band_o   <= BAND_LO;
        out_coef_o   <= hold_coef_q;
        hold_valid_q <= 1'b0;
      end else if (sel_valid) begin
        out_valid_o <= 1'b1;
        out_level_o <= LVL_W'(sel) + LVL_W'(2);
        out_band_o  <= BAND_HI;
        out_coef_o  <= acc[1];
        pe_q[sel]   <= op_e;
        po_q[sel]   <= op_o;
        if (sel == SEL_W'(NLVL - 1)) begin
          hold_valid_q <= 1'b1;
          hold_coef_q  <= acc[0];
        end
      end
      for (int j = 0; j < NLVL; j++) begin
        logic                       push_j, pop_j;
        logic signed [SAMPLE_W-1:0] data_j;
        push_j = (j == 0) ? push_valid_i : (sel_valid && sel == SEL_W'(j - 1));
        data_j = (j == 0) ? push_data_i  : lo_sample;
        pop_j  = sel_valid && sel == SEL_W'(j);
        if (pop_j) begin
          cnt_q[j] <= push_j ? 2'd1 : 2'd0;
          if (push_j) ev_q[j] <= data_j;
        end else if (push_j) begin
          if (cnt_q[j] == 2'd0) begin
            ev_q[j]  <= data_j;
            cnt_q[j] <= 2'd1;
          end else begin
            od_q[j]  <= data_j;
            cnt_q[j] <= 2'd2;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dwt1d_pipe.sv
module dwt1d_pipe import dwt_pkg::*; #(
  parameter int SAMPLE_W   = 12,
  parameter int COEF_W     = 8,
  parameter int ACC_W      = 24,
  parameter int FRAC_SHIFT = 6,
  parameter int MAX_LEVELS = 4,
  parameter int LO_T0 = -4, parameter int LO_T1 = 36,
  parameter int LO_T2 = 36, parameter int LO_T3 = -4,
  parameter int HI_T0 = -4, parameter int HI_T1 = -36,
  parameter int HI_T2 = 36, parameter int HI_T3 = 4,
  localparam int LVL_W = $clog2(MAX_LEVELS + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  output logic                       in_ready_o,
  input  logic signed [SAMPLE_W-1:0] in_even_i,
  input  logic signed [SAMPLE_W-1:0] in_odd_i,
  output logic                       det1_valid_o,
  output logic signed [ACC_W-1:0]    det1_coef_o,
  output logic                       deep_valid_o,
  output logic [LVL_W-1:0]           deep_level_o,
  output logic                       deep_band_o,
  output logic signed [ACC_W-1:0]    deep_coef_o
);
  logic                       fire, lvl2_full;
  logic signed [SAMPLE_W-1:0] appr1;
  band_e                      band;

  assign fire        = in_valid_i && in_ready_o;
  assign deep_band_o = band;

  dwt_stage1 #(
    .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .FRAC_SHIFT(FRAC_SHIFT),
    .LO_T0(LO_T0), .LO_T1(LO_T1), .LO_T2(LO_T2), .LO_T3(LO_T3),
    .HI_T0(HI_T0), .HI_T1(HI_T1), .HI_T2(HI_T2), .HI_T3(HI_T3)
  ) u_stage1 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .even_i     (in_even_i),
    .odd_i      (in_odd_i),
    .det_valid_o(det1_valid_o),
    .det_coef_o (det1_coef_o),
    .appr_o     (appr1)
  );

  dwt_stage2 #(
    .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .FRAC_SHIFT(FRAC_SHIFT),
    .MAX_LEVELS(MAX_LEVELS), .LVL_W(LVL_W),
    .LO_T0(LO_T0), .LO_T1(LO_T1), .LO_T2(LO_T2), .LO_T3(LO_T3),
    .HI_T0(HI_T0), .HI_T1(HI_T1), .HI_T2(HI_T2), .HI_T3(HI_T3)
  ) u_stage2 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_valid_i(fire),
    .push_data_i (appr1),
    .push_ready_o(in_ready_o),
    .l2_full_o   (lvl2_full),
    .out_valid_o (deep_valid_o),
    .out_level_o (deep_level_o),
    .out_band_o  (band),
    .out_coef_o  (deep_coef_o)
  );
endmodule

// File: rtl/dwt1d_pipe_chk.sv
module dwt1d_pipe_chk #(
  parameter int MAX_LEVELS = 4,
  parameter int LVL_W      = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             det1_valid_o,
  input logic             deep_valid_o,
  input logic [LVL_W-1:0] deep_level_o,
  input logic             deep_band_o,
  input logic             lvl2_full_i
);
  // R10
  det1_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> det1_valid_o);

  // R10
  det1_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o) |=> !det1_valid_o);

  // R6
  level_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deep_valid_o |-> (deep_level_o >= LVL_W'(2) && deep_level_o <= LVL_W'(MAX_LEVELS)));

  // R6
  approx_final_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deep_valid_o && !deep_band_o) |-> deep_level_o == LVL_W'(MAX_LEVELS));

  // R8
  stall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> lvl2_full_i);
endmodule

bind dwt1d_pipe dwt1d_pipe_chk #(.MAX_LEVELS(MAX_LEVELS), .LVL_W(LVL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .det1_valid_o(det1_valid_o),
  .deep_valid_o(deep_valid_o),
  .deep_level_o(deep_level_o),
  .deep_band_o (deep_band_o),
  .lvl2_full_i (lvl2_full)
);

// File: tb/sim_dwt1d_pipe.sv
`timescale 1ns/1ps
module sim_dwt1d_pipe;
  localparam int M    = 4;
  localparam int NMAX = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic signed [11:0] in_even = '0, in_odd = '0;
  logic in_ready_o, det1_valid_o, deep_valid_o, deep_band_o;
  logic signed [23:0] det1_coef_o, deep_coef_o;
  logic [2:0] deep_level_o;

  always #10 clk = ~clk;

  dwt1d_pipe u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready_o),
    .in_even_i(in_even), .in_odd_i(in_odd),
    .det1_valid_o(det1_valid_o), .det1_coef_o(det1_coef_o),
    .deep_valid_o(deep_valid_o), .deep_level_o(deep_level_o),
    .deep_band_o(deep_band_o), .deep_coef_o(deep_coef_o)
  );

  int tests = 0, fails = 0;
  int xin [1:M][0:2*NMAX-1];
  int exp_hi [1:M][0:NMAX-1];
  int exp_lo [0:NMAX-1];
  int rc_hi [1:M];
  int rc_lo;
  int n_fire;
  bit mon_en = 0;
  bit fire_q = 0;
  int lfsr = 16'hACE1;

  function automatic int sat12(input int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic int nxt();
    lfsr = ((lfsr >> 1) | (((lfsr ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
    return lfsr;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Behavioural convolve-and-decimate model.
  task automatic build_ref(input int n);
    for (int k = 1; k <= M; k++) begin
      int np;
      np = n >> (k - 1);
      for (int p = 0; p < np; p++) begin
        int e, o, ep, op, lo, hi;
        e  = xin[k][2*p];
        o  = xin[k][2*p+1];
        ep = (p > 0) ? xin[k][2*p-2] : 0;
        op = (p > 0) ? xin[k][2*p-1] : 0;
        lo = -4 * o + 36 * e + 36 * op - 4 * ep;
        hi = -4 * o - 36 * e + 36 * op + 4 * ep;
        exp_hi[k][p] = hi;
        if (k < M) xin[k+1][p] = sat12(lo >>> 6);
        else exp_lo[p] = lo;
      end
    end
  endtask

  always @(posedge clk) begin
    fire_q <= in_valid && in_ready_o;
    if (in_valid && in_ready_o) n_fire <= n_fire + 1;
  end

  always @(negedge clk) begin
    if (mon_en) begin
      if (det1_valid_o || fire_q)
        chk(det1_valid_o == fire_q, "R10 det1 pulse", int'(det1_valid_o), int'(fire_q));
      if (det1_valid_o) begin
        // R2 R3: level-1 detail, first pair uses zero history
        chk(int'(det1_coef_o) == exp_hi[1][rc_hi[1]], "R2/R3 level1 detail",
            int'(det1_coef_o), exp_hi[1][rc_hi[1]]);
        rc_hi[1]++;
      end
      if (deep_valid_o) begin
        int lv;
        lv = int'(deep_level_o);
        if (lv < 2 || lv > M) chk(0, "R6 level tag", lv, M);
        else if (deep_band_o) begin
          // R4 R5 R9: deeper detail from requantised feedback, shared datapath
          chk(int'(deep_coef_o) == exp_hi[lv][rc_hi[lv]], "R4/R5/R9 deep detail",
              int'(deep_coef_o), exp_hi[lv][rc_hi[lv]]);
          rc_hi[lv]++;
        end else if (lv != M) chk(0, "R6 approx only at final level", lv, M);
        else begin
          chk(int'(deep_coef_o) == exp_lo[rc_lo], "R5 final approx",
              int'(deep_coef_o), exp_lo[rc_lo]);
          rc_lo++;
        end
      end
    end
  end

  task automatic do_reset();
    mon_en = 0;
    @(negedge clk);
    in_valid = 0;
    rst_ni = 0;
    repeat (2) @(negedge clk);
    chk(in_ready_o == 1'b1, "R1 ready in reset", int'(in_ready_o), 1);
    chk(!det1_valid_o && !deep_valid_o, "R1 outputs idle in reset",
        int'({det1_valid_o, deep_valid_o}), 0);
    rst_ni = 1;
    for (int k = 1; k <= M; k++) rc_hi[k] = 0;
    rc_lo = 0;
    n_fire = 0;
    @(negedge clk);
    chk(in_ready_o && !det1_valid_o && !deep_valid_o, "R1 state after reset",
        int'({in_ready_o, det1_valid_o, deep_valid_o}), 4);
    mon_en = 1;
  endtask

  // pattern: 0 impulse, 1 +DC, 2 -DC, 3 ramp, 4 pseudo-random, 5 alternating
  task automatic run_case(input int pat, input int n, input bit gaps);
    for (int i = 0; i < 2 * n; i++) begin
      case (pat)
        0: xin[1][i] = (i == 0) ? 1000 : 0;
        1: xin[1][i] = 2047;
        2: xin[1][i] = -2048;
        3: xin[1][i] = (i * 37) % 4096 - 2048;
        4: xin[1][i] = (nxt() & 12'hFFF) - ((nxt() & 1) ? 0 : 0) - 2048;
        default: xin[1][i] = (i % 2 == 0) ? 2047 : -2048;
      endcase
    end
    build_ref(n);
    do_reset();
    for (int p = 0; p < n; p++) begin
      if (gaps && (nxt() & 1)) begin
        // R8: data presented with valid low must be ignored
        in_valid = 0;
        in_even = 12'sh5A5;
        in_odd = -12'sh3C3;
        repeat (1 + (nxt() & 3)) @(negedge clk);
      end
      in_valid = 1;
      in_even = 12'(xin[1][2*p]);
      in_odd = 12'(xin[1][2*p+1]);
      while (!in_ready_o) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 0;
    end
    in_valid = 0;
    repeat (60) @(negedge clk);
    // R7 R8: counts per level and band, no lost or duplicated pair
    chk(n_fire == n, "R8 accepted pairs", n_fire, n);
    for (int k = 1; k <= M; k++)
      chk(rc_hi[k] == (n >> (k - 1)), "R7 detail count", rc_hi[k], n >> (k - 1));
    chk(rc_lo == (n >> (M - 1)), "R7 approx count", rc_lo, n >> (M - 1));
  endtask

  // back-to-back stream: valid held high, drives the shared stage to full load
  task automatic run_stream(input int n);
    for (int i = 0; i < 2 * n; i++) xin[1][i] = (nxt() & 12'hFFF) - 2048;
    build_ref(n);
    do_reset();
    @(negedge clk);
    for (int p = 0; p < n; p++) begin
      in_valid = 1;
      in_even = 12'(xin[1][2*p]);
      in_odd = 12'(xin[1][2*p+1]);
      while (!in_ready_o) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 0;
    repeat (60) @(negedge clk);
    chk(n_fire == n, "R8 accepted pairs under stall", n_fire, n);
    for (int k = 1; k <= M; k++)
      chk(rc_hi[k] == (n >> (k - 1)), "R7 detail count stream", rc_hi[k], n >> (k - 1));
    chk(rc_lo == (n >> (M - 1)), "R7 approx count stream", rc_lo, n >> (M - 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    run_case(0, 16, 0);
    run_case(1, 32, 0);
    run_case(2, 32, 1);
    run_case(3, 64, 1);
    run_case(4, 64, 1);
    run_case(5, 32, 0);
    run_stream(64);
    run_stream(48);
    mon_en = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule